// File: doc/BRIEF.md
# Priority-Ordered Bypass Register

This block is one storage register with several ordered write ports and the same number of ordered read ports. Inside a single clock cycle the ports form a chain: a read port sees the stored value as already modified by every enabled write on a lower-numbered port, and is blind to writes on its own port and above. At the clock edge the register takes the value that one more read port past the last one would see, so the highest-numbered enabled write wins.

The block is a building element for queues and pipeline stages that must let an operation in one cycle see the effect of an earlier operation in the same cycle, for instance a one-entry queue that allows a dequeue and an enqueue together. Callers pick the port number that matches the logical order of their operations; the ordering rules between those operations are the caller's concern.

Read and write ports are packed into flat vectors: port i occupies bits [i*WIDTH +: WIDTH] of the data vectors and bit i of the enable vector.

Top module: `ehr_multiport`

## Requirements
- R1: While `rst` is high at a rising clock edge the register loads the parameter `RST_VAL`; with no write enabled after that, every read port returns `RST_VAL`.
- R2: Read port 0 returns the stored value and does not change with writes enabled in the same cycle.
- R3: Read port 1 returns the data of write port 0 when `wr_en[0]` is 1, and the stored value otherwise.
- R4: Read port k returns the data of the highest-numbered enabled write port below k, or the stored value when no port below k is enabled; write ports at or above k have no effect on it.
- R5: At a rising edge with `rst` low and at least one write enabled, the register loads the data of the highest-numbered enabled write port.
- R6: At a rising edge with `rst` low and no write enabled, the stored value is held whatever the write data lines carry.
- R7: Port i of `wr_data` and `rd_data` occupies bits [i*WIDTH +: WIDTH], and its enable is `wr_en[i]`.
- R8: Reset takes precedence over all enabled writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | NPORTS | Per-port write enable, bit i for port i |
| wr_data | input | NPORTS*WIDTH | Write data, port i in bits [i*WIDTH +: WIDTH] |
| rd_data | output | NPORTS*WIDTH | Read data, port i in bits [i*WIDTH +: WIDTH] |

## Verification
The only internal state is the stored word, and a wrong value there shows on read port 0 in the very next cycle and on every higher read port whose lower writes are all idle. A fault in the bypass chain shows combinationally in the same cycle on the read port just above the broken link, while a fault in the final priority shows only after the following edge, on read port 0. The stimulus therefore drives every enable pattern that separates neighbouring ports and checks both the same-cycle reads and the value loaded one edge later.

// File: rtl/ehr_bypass_link.sv
module ehr_bypass_link #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] upstream_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] downstream_o
);
  // One link of the chain: an enabled write replaces the value seen above it.
  always_comb begin
    downstream_o = wr_en_i ? wr_data_i : upstream_i;
  end
endmodule

// File: rtl/ehr_state_reg.sv
module ehr_state_reg #(
  parameter int             WIDTH   = 8,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= RST_VAL;
    else     q_o <= d_i;
  end
endmodule

// File: rtl/ehr_multiport.sv
module ehr_multiport #(
  parameter int               WIDTH   = 8,
  parameter int               NPORTS  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORTS-1:0]        wr_en,
  input  logic [NPORTS*WIDTH-1:0]  wr_data,
  output logic [NPORTS*WIDTH-1:0]  rd_data
);
  localparam int CHAIN_LEN = NPORTS + 1;

  // chain[k] is what read port k sees; chain[NPORTS] is the next state.
  logic [WIDTH-1:0] chain [CHAIN_LEN];
  logic [WIDTH-1:0] stored;

  assign chain[0] = stored;

  for (genvar p = 0; p < NPORTS; p++) begin : g_link
    ehr_bypass_link #(.WIDTH(WIDTH)) link_i (
      .upstream_i   (chain[p]),
      .wr_en_i      (wr_en[p]),
      .wr_data_i    (wr_data[p*WIDTH +: WIDTH]),
      .downstream_o (chain[p+1])
    );
    assign rd_data[p*WIDTH +: WIDTH] = chain[p];
  end

  ehr_state_reg #(.WIDTH(WIDTH), .RST_VAL(RST_VAL)) state_i (
    .clk (clk),
    .rst (rst),
    .d_i (chain[NPORTS]),
    .q_o (stored)
  );
endmodule

// File: rtl/ehr_multiport_chk.sv
module ehr_multiport_chk #(
  parameter int               WIDTH   = 8,
  parameter int               NPORTS  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NPORTS-1:0]       wr_en,
  input logic [NPORTS*WIDTH-1:0] wr_data,
  input logic [NPORTS*WIDTH-1:0] rd_data
);
  // R1, R8: reset loads the reset value regardless of writes
  a_r1_reset_value: assert property (@(posedge clk)
    rst |=> (rd_data[WIDTH-1:0] == RST_VAL));

  // R6: no write enabled keeps the stored value
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_en == '0) |=> $stable(rd_data[WIDTH-1:0]));

  // R5: the top write port always wins at the edge
  a_r5_top_wins: assert property (@(posedge clk) disable iff (rst)
    wr_en[NPORTS-1] |=> (rd_data[WIDTH-1:0] == $past(wr_data[(NPORTS-1)*WIDTH +: WIDTH])));

  for (genvar k = 1; k < NPORTS; k++) begin : g_chain
    // R3, R4: enabled write below port k is seen directly at port k
    a_r4_bypass: assert property (@(posedge clk) disable iff (rst)
      wr_en[k-1] |-> (rd_data[k*WIDTH +: WIDTH] == wr_data[(k-1)*WIDTH +: WIDTH]));
    // R4: an idle write port passes the lower read value unchanged
    a_r4_pass: assert property (@(posedge clk) disable iff (rst)
      !wr_en[k-1] |-> (rd_data[k*WIDTH +: WIDTH] == rd_data[(k-1)*WIDTH +: WIDTH]));
  end
endmodule

bind ehr_multiport ehr_multiport_chk #(
  .WIDTH(WIDTH), .NPORTS(NPORTS), .RST_VAL(RST_VAL)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
);

// File: tb/ehr_multiport_tb_top.sv
module ehr_multiport_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int N = 3;
  localparam logic [W-1:0] RV = 8'hA5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   wr_en = '0;
  logic [N*W-1:0] wr_data = '0;
  logic [N*W-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ehr_multiport #(.WIDTH(W), .NPORTS(N), .RST_VAL(RV)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [W-1:0] rd(input int p);
    return rd_data[p*W +: W];
  endfunction

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // Drive on the falling edge, then let combinational reads settle.
  task automatic drive(input logic [N-1:0] en, input logic [W-1:0] d0,
                       input logic [W-1:0] d1, input logic [W-1:0] d2);
    @(negedge clk);
    wr_en   = en;
    wr_data = {d2, d1, d0};
    #1;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    drive(3'b000, 8'h00, 8'h00, 8'h00);
    after_edge();
    after_edge();
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 port0", rd(0), RV);
    check("R1 port1", rd(1), RV);
    check("R1 port2", rd(2), RV);
  endtask

  task automatic t_low_port();
    drive(3'b001, 8'h11, 8'hE1, 8'hE2);
    check("R2 port0 ignores write", rd(0), RV);
    check("R3 port1 sees write0", rd(1), 8'h11);
    check("R4 port2 sees write0", rd(2), 8'h11);
    after_edge();
    check("R5 load write0", rd(0), 8'h11);
  endtask

  task automatic t_top_port();
    drive(3'b100, 8'hE3, 8'hE4, 8'h77);
    check("R3 port1 idle write0", rd(1), 8'h11);
    check("R4 port2 blind to own write", rd(2), 8'h11);
    after_edge();
    check("R5 load write2", rd(0), 8'h77);
  endtask

  task automatic t_mid_port();
    drive(3'b010, 8'hE5, 8'h22, 8'hE6);
    check("R4 port1 blind to write1", rd(1), 8'h77);
    check("R4 R7 port2 sees write1", rd(2), 8'h22);
    after_edge();
    check("R5 load write1", rd(0), 8'h22);
  endtask

  task automatic t_priority();
    drive(3'b111, 8'h33, 8'h44, 8'h55);
    check("R2 port0 all enabled", rd(0), 8'h22);
    check("R3 port1 all enabled", rd(1), 8'h33);
    check("R4 port2 higher wins", rd(2), 8'h44);
    after_edge();
    check("R5 top wins all", rd(0), 8'h55);
    drive(3'b011, 8'h66, 8'h88, 8'hE7);
    check("R4 port2 write1 over write0", rd(2), 8'h88);
    after_edge();
    check("R5 write1 over write0", rd(0), 8'h88);
    drive(3'b101, 8'h99, 8'hE8, 8'hBB);
    check("R3 port1 pattern 101", rd(1), 8'h99);
    check("R4 port2 pattern 101", rd(2), 8'h99);
    after_edge();
    check("R5 write2 over write0", rd(0), 8'hBB);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) begin
      drive(3'b000, 8'h0F + 8'(i), 8'hF0, 8'h5A);
      check("R6 port2 idle", rd(2), 8'hBB);
      after_edge();
      check("R6 hold", rd(0), 8'hBB);
    end
  endtask

  task automatic t_reset_vs_write();
    @(negedge clk);
    rst = 1'b1;
    wr_en = 3'b111;
    wr_data = {8'hC3, 8'hC2, 8'hC1};
    after_edge();
    @(negedge clk);
    rst = 1'b0;
    wr_en = '0;
    #1;
    check("R8 reset beats writes", rd(0), RV);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_low_port();
    t_top_port();
    t_mid_port();
    t_priority();
    t_hold();
    t_reset_vs_write();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule